// File: doc/BRIEF.md
# Early-Out Sequential Signed Multiplier

This block is a multi-cycle two's-complement multiplier that serves three operand widths: byte, half-word and word. The caller presents both operands, a width code and a result mode, then pulses `start`. The unit runs a shift-and-add loop over the magnitude of the multiplier. It pads its cycle count so that completion arrives at an exact, data-dependent latency. That latency is set by the number of bits that carry value in the multiplier, so small positive or small negative multipliers finish early.

Two result modes exist. The wide mode returns the exact double-width product. The narrow mode keeps only the low half of the product, at operand width. In both modes the carry and overflow flags report whether the full product would survive being cut down to operand width. The multiplier can also be taken from an 8-bit immediate, which is sign-extended first. A one-cycle `done` pulse marks completion. The result stays on the outputs until the next operation completes.

Top module: `emul_seq_mul`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `cf`, `of` and `product` are all zero.
- R2: `width_sel` selects the operand width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 32 bits. Only the low width bits of each operand are used, read as two's complement. Higher input bits have no effect.
- R3: With `wide_mode`=1, `product` holds the exact signed double-width product, sign-extended to 64 bits. This holds even when the flags are set.
- R4: With `wide_mode`=0, `product` holds the low width bits of the product, sign-extended to 64 bits.
- R5: For a nonzero multiplier m, `done` rises L clock edges after the edge that accepts `start`, where L = max(ceil(log2(|m|)), 3) + 6.
- R6: A zero multiplier completes in exactly 9 cycles.
- R7: For a negative multiplier, the latency rule uses its magnitude |m|. The most negative value therefore takes W+5 cycles at width W.
- R8: `cf` and `of` are equal. Both are 1 exactly when the full signed product differs from the sign extension of its low width bits. This holds in both modes.
- R9: With `imm8_mode`=1, the multiplier is `mplier_in[7:0]` sign-extended to the operand width. Bits above 7 are ignored.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse. `product`, `cf` and `of` change only at the edge that raises `done`.
- R11: `start` is ignored while `busy` is high. The running operation keeps its operands and its latency.
- R12: The most negative operands give correct results. For example, -128 × -128 at 8 bits gives 16384 in wide mode, and gives 0 with both flags set in narrow mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a multiply; taken only when idle |
| mcand_in | input | DATA_W | Multiplicand (low width bits used) |
| mplier_in | input | DATA_W | Multiplier, or immediate in bits 7:0 |
| width_sel | input | 2 | Operand width code |
| wide_mode | input | 1 | 1 = double-width product, 0 = same-width product |
| imm8_mode | input | 1 | 1 = multiplier is sign-extended 8-bit immediate |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*DATA_W | Result, sign-extended |
| cf | output | 1 | Carry flag: product does not fit operand width |
| of | output | 1 | Overflow flag, same rule as cf |

## Verification
The bound checker watches the handshake shape on every cycle: `done` is a lone pulse that never coincides with `busy`, and `busy` only drops through `done`. It also checks that the two flags agree, that the result outputs hold still outside a completion edge, and that each completion falls inside the overall latency window. Only the bench scenarios can show the exact per-operand latency, the numeric products in both modes, the immediate sign extension, the masking of unused operand bits and the refusal of a mid-operation `start`, because these need expected values computed from the operands.

// File: rtl/emul_pkg.sv
// Shared types for the early-out sequential multiplier.
// Assumes the operand width set is fixed at quarter, half and full DATA_W.
package emul_pkg;
    typedef enum logic [1:0] {
        W_BYTE     = 2'd0,
        W_HALF     = 2'd1,
        W_WORD     = 2'd2,
        W_WORD_ALT = 2'd3
    } opw_e;
endpackage

// File: rtl/emul_operand_prep.sv
// Operand preparation: sign-extends both operands from the selected width,
// applies the 8-bit immediate option, and produces the unsigned magnitudes,
// the product sign and the target latency for the early-out rule.
// Assumes DATA_W is a multiple of 4 and at least 32; CNT_W holds DATA_W+6.
module emul_operand_prep
    import emul_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic [DATA_W-1:0] a_raw,
    input  logic [DATA_W-1:0] b_raw,
    input  opw_e              wid,
    input  logic              imm_sel,
    output logic [DATA_W-1:0] a_mag,
    output logic [DATA_W-1:0] b_mag,
    output logic              prod_neg,
    output logic [CNT_W-1:0]  lat
);
    localparam int QW       = DATA_W / 4;
    localparam int HW       = DATA_W / 2;
    localparam int MIN_SPAN = 3;
    localparam int FIXED    = 6;

    // Sign-extend a value from the selected operand width to DATA_W.
    function automatic logic [DATA_W-1:0] widen(input logic [DATA_W-1:0] v, input opw_e w);
        case (w)
            W_BYTE:  widen = {{(DATA_W-QW){v[QW-1]}}, v[QW-1:0]};
            W_HALF:  widen = {{(DATA_W-HW){v[HW-1]}}, v[HW-1:0]};
            default: widen = v;
        endcase
    endfunction

    // Absolute value as an unsigned number (most negative value maps to 2^(DATA_W-1)).
    function automatic logic [DATA_W-1:0] magnitude(input logic [DATA_W-1:0] v);
        magnitude = v[DATA_W-1] ? (~v + 1'b1) : v;
    endfunction

    logic [DATA_W-1:0] a_ext, b_src, b_ext, dec;
    logic [CNT_W-1:0]  span;

    // Operand extension and immediate selection.
    always_comb begin
        a_ext = widen(a_raw, wid);
        b_src = imm_sel ? {{(DATA_W-8){b_raw[7]}}, b_raw[7:0]} : b_raw;
        b_ext = widen(b_src, wid);
    end

    // Magnitudes and sign of the eventual product.
    always_comb begin
        a_mag    = magnitude(a_ext);
        b_mag    = magnitude(b_ext);
        prod_neg = a_ext[DATA_W-1] ^ b_ext[DATA_W-1];
    end

    // ceil(log2(|m|)) equals the bit length of |m|-1; zero multiplier gives zero.
    always_comb begin
        dec  = b_mag - 1'b1;
        span = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (dec[i]) span = CNT_W'(i + 1);
        end
        if (b_mag == '0) span = '0;
    end

    // Latency target: floor at the minimum span, plus the fixed overhead.
    always_comb begin
        lat = ((span < CNT_W'(MIN_SPAN)) ? CNT_W'(MIN_SPAN) : span) + CNT_W'(FIXED);
    end
endmodule

// File: rtl/emul_shift_add.sv
// Unsigned shift-and-add engine: one multiplier bit per step, LSB first.
// Stops adding once the remaining multiplier bits are all zero, so the number
// of useful steps equals the bit length of the multiplier magnitude.
// Assumes the controller gives at least that many steps before reading acc.
module emul_shift_add #(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  step,
    input  logic [DATA_W-1:0]     mcand,
    input  logic [DATA_W-1:0]     mplier,
    output logic [2*DATA_W-1:0]   acc
);
    localparam int PROD_W = 2 * DATA_W;

    logic [PROD_W-1:0] addend;
    logic [DATA_W-1:0] rest;

    // Load operands on accept, then add the shifted multiplicand per set bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc    <= '0;
            addend <= '0;
            rest   <= '0;
        end else if (load) begin
            acc    <= '0;
            addend <= {{DATA_W{1'b0}}, mcand};
            rest   <= mplier;
        end else if (step && (rest != '0)) begin
            if (rest[0]) acc <= acc + addend;
            addend <= addend << 1;
            rest   <= rest >> 1;
        end
    end
endmodule

// File: rtl/emul_result_fmt.sv
// Result formatting: applies the product sign to the magnitude, builds the
// narrow (operand-width, sign-extended) view, selects the output by mode and
// raises the overflow indication when the narrow view loses information.
// Assumes mag_prod is the exact unsigned product of the operand magnitudes.
module emul_result_fmt
    import emul_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [2*DATA_W-1:0] mag_prod,
    input  logic                neg,
    input  opw_e                wid,
    input  logic                dbl,
    output logic [2*DATA_W-1:0] res,
    output logic                ovf
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int QW     = DATA_W / 4;
    localparam int HW     = DATA_W / 2;

    logic [PROD_W-1:0] full, narrow;

    // Signed full product.
    always_comb begin
        full = neg ? (~mag_prod + 1'b1) : mag_prod;
    end

    // Low operand-width bits of the product, sign-extended.
    always_comb begin
        case (wid)
            W_BYTE:  narrow = {{(PROD_W-QW){full[QW-1]}}, full[QW-1:0]};
            W_HALF:  narrow = {{(PROD_W-HW){full[HW-1]}}, full[HW-1:0]};
            default: narrow = {{(PROD_W-DATA_W){full[DATA_W-1]}}, full[DATA_W-1:0]};
        endcase
    end

    // Mode selection and fit test.
    always_comb begin
        res = dbl ? full : narrow;
        ovf = (full != narrow);
    end
endmodule

// File: rtl/emul_seq_mul.sv
// Top level of the early-out sequential signed multiplier.
// Accepts an operation when idle, runs the shift-add engine while a cycle
// counter climbs to the data-dependent target, then registers the result and
// flags and pulses done. Assumes inputs are stable only in the start cycle.
module emul_seq_mul
    import emul_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [DATA_W-1:0]     mcand_in,
    input  logic [DATA_W-1:0]     mplier_in,
    input  logic [1:0]            width_sel,
    input  logic                  wide_mode,
    input  logic                  imm8_mode,
    output logic                  busy,
    output logic                  done,
    output logic [2*DATA_W-1:0]   product,
    output logic                  cf,
    output logic                  of
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(DATA_W + 8) + 1;

    logic [DATA_W-1:0] a_mag, b_mag;
    logic              neg_now;
    logic [CNT_W-1:0]  lat_now;
    logic [PROD_W-1:0] acc;
    logic [PROD_W-1:0] fmt_res;
    logic              fmt_ovf;

    logic [CNT_W-1:0]  tick, goal;
    opw_e              wid_q;
    logic              dbl_q, neg_q;
    logic              accept, finish;

    emul_operand_prep #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_prep (
        .a_raw    (mcand_in),
        .b_raw    (mplier_in),
        .wid      (opw_e'(width_sel)),
        .imm_sel  (imm8_mode),
        .a_mag    (a_mag),
        .b_mag    (b_mag),
        .prod_neg (neg_now),
        .lat      (lat_now)
    );

    emul_shift_add #(.DATA_W(DATA_W)) u_engine (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (busy && !finish),
        .mcand  (a_mag),
        .mplier (b_mag),
        .acc    (acc)
    );

    emul_result_fmt #(.DATA_W(DATA_W)) u_fmt (
        .mag_prod (acc),
        .neg      (neg_q),
        .wid      (wid_q),
        .dbl      (dbl_q),
        .res      (fmt_res),
        .ovf      (fmt_ovf)
    );

    // Handshake decode: take start only when idle; end when the count hits the goal.
    always_comb begin
        accept = start && !busy;
        finish = busy && (tick == goal);
    end

    // Control, cycle padding and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            tick    <= '0;
            goal    <= '0;
            wid_q   <= W_BYTE;
            dbl_q   <= 1'b0;
            neg_q   <= 1'b0;
            product <= '0;
            cf      <= 1'b0;
            of      <= 1'b0;
        end else begin
            done <= finish;
            if (accept) begin
                busy  <= 1'b1;
                tick  <= CNT_W'(1);
                goal  <= lat_now;
                wid_q <= opw_e'(width_sel);
                dbl_q <= wide_mode;
                neg_q <= neg_now;
            end else if (finish) begin
                busy    <= 1'b0;
                product <= fmt_res;
                cf      <= fmt_ovf;
                of      <= fmt_ovf;
            end else if (busy) begin
                tick <= tick + 1'b1;
            end
        end
    end
endmodule

// File: rtl/emul_seq_mul_chk.sv
// Protocol and invariant checker for emul_seq_mul, attached by bind.
// Assumes synchronous active-low reset on rst_n.
module emul_seq_mul_chk #(
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                busy,
    input logic                done,
    input logic [2*DATA_W-1:0] product,
    input logic                cf,
    input logic                of
);
    logic [7:0] run_len;

    // Count edges since the accepted start (1 after the accepting edge).
    always_ff @(posedge clk) begin
        if (!rst_n)              run_len <= '0;
        else if (start && !busy) run_len <= 8'd1;
        else if (busy)           run_len <= run_len + 8'd1;
    end

    // R10
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    busy_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    // R10
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(product) && $stable(cf) && $stable(of)));

    // R8
    flag_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cf == of);

    // R5
    latency_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len >= 8'd10 && run_len <= 8'(DATA_W + 7)));

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> !done);
endmodule

bind emul_seq_mul emul_seq_mul_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .product (product),
    .cf      (cf),
    .of      (of)
);

// File: tb/tb_emul_seq_mul.sv
`timescale 1ns/1ps
module tb_emul_seq_mul;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] mcand_in = '0;
    logic [31:0] mplier_in = '0;
    logic [1:0]  width_sel = '0;
    logic        wide_mode = 1'b0;
    logic        imm8_mode = 1'b0;
    logic        busy, done, cf, of;
    logic [63:0] product;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    emul_seq_mul #(.DATA_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mcand_in(mcand_in),
        .mplier_in(mplier_in), .width_sel(width_sel), .wide_mode(wide_mode),
        .imm8_mode(imm8_mode), .busy(busy), .done(done), .product(product),
        .cf(cf), .of(of)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++;
            bad++;
            $display("FAIL R10 watchdog: cycles=%0d expected below 150000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic longint sx(input longint v, input int w);
        longint t;
        t = v <<< (64 - w);
        return t >>> (64 - w);
    endfunction

    function automatic int wbits(input logic [1:0] ws);
        return (ws == 2'd0) ? 8 : (ws == 2'd1) ? 16 : 32;
    endfunction

    function automatic longint eff_mplier(input logic [31:0] b, input logic [1:0] ws, input bit imm);
        return imm ? sx(longint'(b[7:0]), 8) : sx(longint'(b), wbits(ws));
    endfunction

    function automatic int exp_lat(input longint m);
        longint mag;
        int c;
        mag = (m < 0) ? -m : m;
        c = 0;
        while ((64'sd1 <<< c) < mag) c++;
        return ((c < 3) ? 3 : c) + 6;
    endfunction

    // Issue one operation, measure its latency and check result, flags, latency.
    task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [1:0] ws,
                          input bit dbl, input bit imm, input string rq);
        int cyc;
        bit got;
        int w;
        longint pa, pb, full, narrow, expv;
        w = wbits(ws);
        pa = sx(longint'(a), w);
        pb = eff_mplier(b, ws, imm);
        full = pa * pb;
        narrow = sx(full, w);
        expv = dbl ? full : narrow;
        @(negedge clk);
        mcand_in = a; mplier_in = b; width_sel = ws; wide_mode = dbl; imm8_mode = imm;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        mcand_in = $urandom; mplier_in = $urandom;
        chk({rq, " R10 busy after start"}, longint'(busy), 1);
        cyc = 0; got = 0;
        while (!got && cyc < 100) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done) got = 1;
        end
        chk({rq, " R5 latency"}, cyc, exp_lat(pb));
        chk({rq, " R3/R4 product"}, longint'(product), expv);
        chk({rq, " R8 flags"}, longint'({cf, of}), (full != narrow) ? 3 : 0);
    endtask

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 busy", longint'(busy), 0);
        chk("R1 done", longint'(done), 0);
        chk("R1 product", longint'(product), 0);
        chk("R1 flags", longint'({cf, of}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", longint'({busy, done, cf, of}), 0);

        // R12: most negative operands, both modes, all widths
        run_op(32'h80, 32'h80, 2'd0, 1'b1, 1'b0, "R12 byte wide");
        chk("R12 byte wide value", longint'(product), 16384);
        run_op(32'h80, 32'h80, 2'd0, 1'b0, 1'b0, "R12 byte narrow");
        chk("R12 byte narrow flags", longint'({cf, of}), 3);
        run_op(32'h8000, 32'h8000, 2'd1, 1'b1, 1'b0, "R12 half wide");
        run_op(32'h80000000, 32'h80000000, 2'd2, 1'b1, 1'b0, "R12 word wide");
        run_op(32'h7fffffff, 32'h80000000, 2'd2, 1'b0, 1'b0, "R12 word narrow");

        // R6: zero multiplier; R5 small values
        run_op(32'h1234, 32'h0, 2'd2, 1'b1, 1'b0, "R6 zero");
        run_op(32'd77, 32'd1, 2'd2, 1'b1, 1'b0, "R5 one");
        run_op(32'd77, 32'd9, 2'd0, 1'b1, 1'b0, "R5 nine");
        run_op(32'd3, 32'h7fff, 2'd1, 1'b0, 1'b0, "R5 half max");
        // R7: negative multipliers
        run_op(32'd5, 32'hffffffff, 2'd2, 1'b1, 1'b0, "R7 minus one");
        run_op(32'd5, 32'hfffffe00, 2'd2, 1'b1, 1'b0, "R7 minus 512");
        run_op(32'd100, 32'hff81, 2'd1, 1'b0, 1'b0, "R7 half neg");

        // R2: upper operand bits ignored, code 3 behaves as 32 bits
        run_op(32'hffffff05, 32'h123400fd, 2'd0, 1'b1, 1'b0, "R2 byte mask");
        chk("R2 byte mask value", longint'(product), -15);
        run_op(32'hdead0100, 32'hbeef0200, 2'd1, 1'b0, 1'b0, "R2 half mask");
        run_op(32'h00012345, 32'hfff00001, 2'd3, 1'b1, 1'b0, "R2 code3");

        // R9: immediate sign extension, high bits ignored
        run_op(32'd1000, 32'habcd12f0, 2'd2, 1'b1, 1'b1, "R9 imm neg");
        chk("R9 imm value", longint'(product), -16000);
        run_op(32'd300, 32'h0000ff7f, 2'd1, 1'b0, 1'b1, "R9 imm pos");

        // R11: start while busy is ignored
        @(negedge clk);
        mcand_in = 32'd7; mplier_in = 32'd100; width_sel = 2'd2; wide_mode = 1'b1; imm8_mode = 1'b0;
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        mcand_in = 32'd3; mplier_in = 32'hffffffff; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11 still busy", longint'(busy), 1);
        begin
            int cyc = 3;
            while (!done && cyc < 100) begin @(negedge clk); cyc++; end
            chk("R11 latency kept", cyc, exp_lat(100));
        end
        chk("R11 product kept", longint'(product), 700);

        // R10: outputs hold after done, pulse is single
        @(negedge clk);
        chk("R10 done pulse", longint'(done), 0);
        repeat (5) @(negedge clk);
        chk("R10 hold", longint'(product), 700);

        // Constrained random mix
        for (int i = 0; i < 300; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom >> ($urandom % 32);
            rb = $urandom >> ($urandom % 32);
            if ($urandom % 2) ra = -ra;
            if ($urandom % 2) rb = -rb;
            run_op(ra, rb, 2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 8 == 0), "R3 random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule